// File: doc/BRIEF.md
# Register-Mapped Iterative Integer Divider with Zero-Divisor Trap

This block divides one 32-bit integer by another, either as two's-complement signed values or as unsigned values, and is reached through a small word-indexed register port. Software writes the dividend and a control word, then writes the divisor. The divisor write launches a shift-subtract loop that resolves one quotient bit per clock. While the loop runs, a busy bit is visible in the control/status word. The single result register returns either the quotient or the remainder, depending on a selector bit that is sampled when the register is read.

A divisor of zero never enters the loop. It sets a sticky status flag and forces both the quotient and the remainder to zero. If the trap enable bit is also set, every read of the result register ends with an error response in place of data. A read of the result register while the loop is still running holds the port in wait states until the answer is ready, so software can read it straight after starting.

Top module: `regdiv_top`

## Requirements
- R1: With bit 0 of the control/status word (index 2) clear, the operands are unsigned and the result is the truncated unsigned quotient and the remainder.
- R2: With bit 0 set, the operands are two's complement. The quotient truncates toward zero and the remainder carries the sign of the dividend. 0x80000000 divided by 0xFFFFFFFF gives quotient 0x80000000 and remainder 0.
- R3: A read of the result register (index 3) returns the remainder when bit 1 of the control/status word is set and the quotient when it is clear.
- R4: A write to the divisor register (index 1) with a nonzero value starts a division. Bit 5 of the control/status word reads 1 for exactly W+1 clock cycles (33 by default) after the cycle that accepts the write, and then reads 0.
- R5: A read of the result register while a division is running holds bus_ready low until the division ends. It then completes with the final value. A read issued in the cycle after the divisor write waits W+1 cycles.
- R6: A divisor write of zero does not set bit 5. In the next cycle it sets the divide-by-zero flag (bit 4), and the quotient and the remainder both read as 0, even when an earlier division left nonzero values.
- R7: While bit 4 and the trap enable (bit 2) are both 1, a read of the result register completes with bus_ready and bus_err both high. With the trap enable clear, bus_err stays low.
- R8: Bit 4 stays set across other register writes. It clears only when a divisor write with a nonzero value starts a new division.
- R9: After reset, the dividend, the divisor, the control/status word and the result all read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_req | input | 1 | Transfer request, held until bus_ready is high |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 2 | Word index: 0 dividend, 1 divisor, 2 control/status, 3 result |
| bus_wdata | input | W | Write data |
| bus_rdata | output | W | Read data, valid while bus_ready is high |
| bus_ready | output | 1 | Transfer completes in this cycle |
| bus_err | output | 1 | Completing read ended with an error response |

## Verification
Most wrong internal state in the loop stays hidden until the loop ends. A bad partial remainder, a wrong sign flag or a dropped quotient bit first shows as a wrong result-register value, W+1 cycles after the divisor write. The vectors therefore cover every sign combination, remainder selection and the extreme magnitudes. Counter or state errors show sooner and more directly: the number of wait states on a result read or the number of polls that see the busy bit changes. Flag and trap mistakes show on the very next status or result read, one cycle after the divisor write.

// File: rtl/regdiv_pkg.sv
package regdiv_pkg;

    localparam int IDX_W = 2;

    typedef enum logic [1:0] {
        ENG_IDLE,
        ENG_RUN,
        ENG_FIX
    } eng_state_e;

    typedef enum logic [IDX_W-1:0] {
        REG_DVD = 2'd0,
        REG_DVS = 2'd1,
        REG_CSR = 2'd2,
        REG_RES = 2'd3
    } reg_idx_e;

    localparam int CSR_SIGNED = 0;
    localparam int CSR_REMSEL = 1;
    localparam int CSR_TRAP   = 2;
    localparam int CSR_DZ     = 4;
    localparam int CSR_BUSY   = 5;

endpackage

// File: rtl/regdiv_mag.sv
module regdiv_mag #(
    parameter int W = 32
) (
    input  logic [W-1:0] val,
    input  logic         is_signed,
    output logic [W-1:0] mag,
    output logic         neg
);

    always_comb begin
        neg = is_signed & val[W-1];
        mag = neg ? (~val + 1'b1) : val;
    end

endmodule

// File: rtl/regdiv_engine.sv
module regdiv_engine
    import regdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         is_signed,
    input  logic [W-1:0] dvd,
    input  logic [W-1:0] dvs,
    output logic         busy,
    output logic         dz,
    output logic [W-1:0] quo,
    output logic [W-1:0] rem
);

    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        eng_state_e   st;
        logic [CW-1:0] cnt;
        logic [W-1:0] acc;
        logic [W-1:0] shq;
        logic [W-1:0] dmag;
        logic [W-1:0] q_out;
        logic [W-1:0] r_out;
        logic         neg_q;
        logic         neg_r;
        logic         dz;
    } eng_t;

    eng_t s_d, s_q;

    logic [W-1:0] dvd_mag, dvs_mag;
    logic         dvd_neg, dvs_neg;
    logic [W:0]   trial;

    regdiv_mag #(.W(W)) u_mag_dvd (
        .val       (dvd),
        .is_signed (is_signed),
        .mag       (dvd_mag),
        .neg       (dvd_neg)
    );

    regdiv_mag #(.W(W)) u_mag_dvs (
        .val       (dvs),
        .is_signed (is_signed),
        .mag       (dvs_mag),
        .neg       (dvs_neg)
    );

    always_comb trial = {s_q.acc, s_q.shq[W-1]} - {1'b0, s_q.dmag};

    always_comb begin
        s_d = s_q;
        if (start) begin
            if (dvs == '0) begin
                s_d.st    = ENG_IDLE;
                s_d.dz    = 1'b1;
                s_d.q_out = '0;
                s_d.r_out = '0;
            end else begin
                s_d.st    = ENG_RUN;
                s_d.cnt   = CW'(W);
                s_d.acc   = '0;
                s_d.shq   = dvd_mag;
                s_d.dmag  = dvs_mag;
                s_d.neg_q = dvd_neg ^ dvs_neg;
                s_d.neg_r = dvd_neg;
                s_d.dz    = 1'b0;
            end
        end else begin
            case (s_q.st)
                ENG_RUN: begin
                    if (!trial[W]) begin
                        s_d.acc = trial[W-1:0];
                        s_d.shq = {s_q.shq[W-2:0], 1'b1};
                    end else begin
                        s_d.acc = {s_q.acc[W-2:0], s_q.shq[W-1]};
                        s_d.shq = {s_q.shq[W-2:0], 1'b0};
                    end
                    s_d.cnt = s_q.cnt - 1'b1;
                    if (s_q.cnt == CW'(1)) s_d.st = ENG_FIX;
                end
                ENG_FIX: begin
                    s_d.q_out = s_q.neg_q ? (~s_q.shq + 1'b1) : s_q.shq;
                    s_d.r_out = s_q.neg_r ? (~s_q.acc + 1'b1) : s_q.acc;
                    s_d.st    = ENG_IDLE;
                end
                default: s_d.st = ENG_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_comb begin
        busy = (s_q.st != ENG_IDLE);
        dz   = s_q.dz;
        quo  = s_q.q_out;
        rem  = s_q.r_out;
    end

    // R6: a zero divisor finishes at once with a flagged zero result
    p_zero_start_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dvs == '0) |=> (!busy && dz && quo == '0 && rem == '0));

    // R8: a nonzero start clears the flag and raises busy
    p_nonzero_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (start && dvs != '0) |=> (busy && !dz));

    // R4: the loop counter never runs dry while iterating
    p_run_cnt_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.st == ENG_RUN) |-> (s_q.cnt != '0 && s_q.cnt <= CW'(W)));

    // R4: completion always passes through the sign fix-up cycle
    p_fall_after_fix_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> ($past(s_q.st) == ENG_FIX));

endmodule

// File: rtl/regdiv_top.sv
module regdiv_top
    import regdiv_pkg::*;
#(
    parameter int W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_req,
    input  logic             bus_wr,
    input  logic [IDX_W-1:0] bus_addr,
    input  logic [W-1:0]     bus_wdata,
    output logic [W-1:0]     bus_rdata,
    output logic             bus_ready,
    output logic             bus_err
);

    typedef struct packed {
        logic [W-1:0] dvd;
        logic [W-1:0] dvs;
        logic         sgn;
        logic         remsel;
        logic         trap;
    } top_t;

    top_t r_d, r_q;

    reg_idx_e     idx;
    logic         blocked, wr_en, start;
    logic         eng_busy, eng_dz;
    logic [W-1:0] eng_quo, eng_rem, csr_word;

    regdiv_engine #(.W(W)) u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .is_signed (r_q.sgn),
        .dvd       (r_q.dvd),
        .dvs       (bus_wdata),
        .busy      (eng_busy),
        .dz        (eng_dz),
        .quo       (eng_quo),
        .rem       (eng_rem)
    );

    always_comb begin
        idx       = reg_idx_e'(bus_addr);
        blocked   = eng_busy && ((idx == REG_RES && !bus_wr) ||
                                 (idx == REG_DVS && bus_wr));
        bus_ready = bus_req && !blocked;
        wr_en     = bus_ready && bus_wr;
        start     = wr_en && (idx == REG_DVS);

        r_d = r_q;
        if (wr_en) begin
            case (idx)
                REG_DVD: r_d.dvd = bus_wdata;
                REG_DVS: r_d.dvs = bus_wdata;
                REG_CSR: begin
                    r_d.sgn    = bus_wdata[CSR_SIGNED];
                    r_d.remsel = bus_wdata[CSR_REMSEL];
                    r_d.trap   = bus_wdata[CSR_TRAP];
                end
                default: ;
            endcase
        end

        csr_word             = '0;
        csr_word[CSR_SIGNED] = r_q.sgn;
        csr_word[CSR_REMSEL] = r_q.remsel;
        csr_word[CSR_TRAP]   = r_q.trap;
        csr_word[CSR_DZ]     = eng_dz;
        csr_word[CSR_BUSY]   = eng_busy;

        bus_rdata = '0;
        bus_err   = 1'b0;
        if (bus_ready && !bus_wr) begin
            case (idx)
                REG_DVD: bus_rdata = r_q.dvd;
                REG_DVS: bus_rdata = r_q.dvs;
                REG_CSR: bus_rdata = csr_word;
                default: begin
                    if (r_q.trap && eng_dz) bus_err = 1'b1;
                    else bus_rdata = r_q.remsel ? eng_rem : eng_quo;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // R5: a result read during a running division is held off
    p_stall_res_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_wr && bus_addr == REG_RES && eng_busy) |-> !bus_ready);

    // R7: an error response needs a completing transfer, a set flag and the trap enabled
    p_err_needs_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> (bus_ready && eng_dz && r_q.trap && !eng_busy));

    // R4: a start is never accepted on top of a running division
    p_no_restart_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !eng_busy);

    // R6: an idle engine with the flag set holds zero results
    p_zero_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_dz && !eng_busy) |-> (eng_quo == '0 && eng_rem == '0));

endmodule

// File: tb/regdiv_top_tb.sv
module regdiv_top_tb;
    import regdiv_pkg::*;

    localparam int W    = 32;
    localparam int NVEC = 14;

    // each entry: {signed, remsel, dividend, divisor, expected}
    localparam logic [97:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 32'd100,        32'd7,          32'd14},
        {1'b0, 1'b1, 32'd100,        32'd7,          32'd2},
        {1'b0, 1'b0, 32'hFFFFFFFF,   32'd1,          32'hFFFFFFFF},
        {1'b0, 1'b1, 32'hFFFFFFFF,   32'h00010000,   32'h0000FFFF},
        {1'b1, 1'b0, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFD},
        {1'b1, 1'b1, 32'hFFFFFFF9,   32'd2,          32'hFFFFFFFF},
        {1'b1, 1'b0, 32'd7,          32'hFFFFFFFE,   32'hFFFFFFFD},
        {1'b1, 1'b1, 32'd7,          32'hFFFFFFFE,   32'd1},
        {1'b1, 1'b1, 32'hFFFFFFF9,   32'hFFFFFFFE,   32'hFFFFFFFF},
        {1'b1, 1'b0, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
        {1'b0, 1'b1, 32'h80000000,   32'hFFFFFFFF,   32'h80000000},
        {1'b0, 1'b1, 32'd5,          32'd9,          32'd5},
        {1'b1, 1'b0, 32'h80000000,   32'd2,          32'hC0000000},
        {1'b0, 1'b0, 32'hFFFFFFF9,   32'd2,          32'h7FFFFFFC}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             bus_req = 1'b0;
    logic             bus_wr = 1'b0;
    logic [IDX_W-1:0] bus_addr = '0;
    logic [W-1:0]     bus_wdata = '0;
    logic [W-1:0]     bus_rdata;
    logic             bus_ready;
    logic             bus_err;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    regdiv_top #(.W(W)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_req   (bus_req),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .bus_ready (bus_ready),
        .bus_err   (bus_err)
    );

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic xfer(input logic wr, input logic [IDX_W-1:0] a, input logic [W-1:0] wd,
                        output logic [W-1:0] rd, output logic er, output int waits);
        @(negedge clk);
        bus_req = 1'b1; bus_wr = wr; bus_addr = a; bus_wdata = wd;
        #1;
        waits = 0;
        while (!bus_ready) begin
            @(negedge clk);
            #1;
            waits++;
        end
        rd = bus_rdata;
        er = bus_err;
        @(posedge clk);
        #1;
        bus_req = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic wr_reg(input logic [IDX_W-1:0] a, input logic [W-1:0] d);
        logic [W-1:0] rd; logic er; int wt;
        xfer(1'b1, a, d, rd, er, wt);
    endtask

    task automatic rd_reg(input logic [IDX_W-1:0] a, output logic [W-1:0] d,
                          output logic er, output int wt);
        xfer(1'b0, a, '0, d, er, wt);
    endtask

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R5 watchdog actual=hung expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [W-1:0] d;
        logic er;
        int wt;
        int polls;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R9: reset state
        rd_reg(REG_CSR, d, er, wt); chk("R9 csr", d, 32'h0);
        rd_reg(REG_RES, d, er, wt); chk("R9 result", d, 32'h0);
        rd_reg(REG_DVD, d, er, wt); chk("R9 dividend", d, 32'h0);
        rd_reg(REG_DVS, d, er, wt); chk("R9 divisor", d, 32'h0);

        // R1 R2 R3: vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [97:0] v;
            string tag;
            v = VEC[i];
            tag = $sformatf("%s%s vec%0d", v[97] ? "R2" : "R1", v[96] ? "/R3" : "", i);
            wr_reg(REG_CSR, {30'd0, v[96], v[97]});
            wr_reg(REG_DVD, v[95:64]);
            wr_reg(REG_DVS, v[63:32]);
            rd_reg(REG_RES, d, er, wt);
            chk(tag, d, v[31:0]);
        end

        // R3: flip selector after completion, same division
        wr_reg(REG_CSR, 32'h0);
        rd_reg(REG_RES, d, er, wt); chk("R3 quotient after flip", d, 32'h7FFFFFFC);
        wr_reg(REG_CSR, 32'h2);
        rd_reg(REG_RES, d, er, wt); chk("R3 remainder after flip", d, 32'h1);

        // R5: stall length on immediate result read
        wr_reg(REG_CSR, 32'h0);
        wr_reg(REG_DVD, 32'd1000);
        wr_reg(REG_DVS, 32'd10);
        rd_reg(REG_RES, d, er, wt);
        chk("R5 wait states", 32'(wt), 32'(W + 1));
        chk("R5 stalled value", d, 32'd100);

        // R4: busy bit duration by polling
        wr_reg(REG_DVS, 32'd3);
        polls = 0;
        rd_reg(REG_CSR, d, er, wt);
        chk("R4 busy right after start", {31'd0, d[CSR_BUSY]}, 32'd1);
        while (d[CSR_BUSY] && polls < 200) begin
            polls++;
            rd_reg(REG_CSR, d, er, wt);
        end
        chk("R4 busy cycles", 32'(polls), 32'(W + 1));
        rd_reg(REG_RES, d, er, wt); chk("R4 result 1000/3", d, 32'd333);

        // R6: zero divisor after a nonzero result
        wr_reg(REG_DVD, 32'd123);
        wr_reg(REG_DVS, 32'd0);
        rd_reg(REG_CSR, d, er, wt);
        chk("R6 flag set", {31'd0, d[CSR_DZ]}, 32'd1);
        chk("R6 not busy", {31'd0, d[CSR_BUSY]}, 32'd0);
        rd_reg(REG_RES, d, er, wt);
        chk("R6 quotient zero", d, 32'h0);
        chk("R6 no wait", 32'(wt), 32'd0);
        chk("R7 no error with trap off", {31'd0, er}, 32'd0);
        wr_reg(REG_CSR, 32'h2);
        rd_reg(REG_RES, d, er, wt);
        chk("R6 remainder zero", d, 32'h0);

        // R7: trap enabled gives error response
        wr_reg(REG_CSR, 32'h6);
        rd_reg(REG_RES, d, er, wt);
        chk("R7 error response", {31'd0, er}, 32'd1);

        // R8: flag survives other writes, clears on nonzero start
        wr_reg(REG_CSR, 32'h6);
        wr_reg(REG_DVD, 32'd123);
        rd_reg(REG_CSR, d, er, wt);
        chk("R8 flag sticky", {31'd0, d[CSR_DZ]}, 32'd1);
        wr_reg(REG_DVS, 32'd5);
        rd_reg(REG_CSR, d, er, wt);
        chk("R8 flag cleared", {31'd0, d[CSR_DZ]}, 32'd0);
        rd_reg(REG_RES, d, er, wt);
        chk("R8 no error after clear", {31'd0, er}, 32'd0);
        chk("R8 remainder 123/5", d, 32'd3);
        wr_reg(REG_CSR, 32'h4);
        rd_reg(REG_RES, d, er, wt);
        chk("R8 quotient 123/5", d, 32'd24);

        done = 1'b1;
        summary();
        $finish;
    end

endmodule